// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single line. It is paced by a strobe that runs at eight times the bit rate and is one clock wide. The line can come from the external pin or, for self-test, from the local transmitter output. Character length and parity handling are chosen by small configuration codes, which the matching transmitter also uses. The configuration must be held steady while a character is in flight.

Each completed character comes out as a one-cycle strobe with the data and a single error flag. If the downstream receive queue reports full when a character completes, that character is dropped and a separate overrun strobe fires in its place. When automatic flow control is on, a request-to-send output follows the queue's almost-full indication.

Top module: `uart_rx_core`

## Requirements
- R1: While reset is held, `rx_valid_o`, `rx_ovr_o`, `rx_err_o` and `rts_o` are all 0.
- R2: `wlen_code_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits are received least significant first. Bit positions at and above the selected length read as 0 in `rx_data_o`.
- R3: `par_code_i` 0 means no parity bit. 4 means odd parity (data plus parity bit hold an odd count of ones). 5 means the parity bit must be 1. 6 means even parity. 7 means the parity bit must be 0. Codes 1 to 3 behave like code 0.
- R4: `rx_err_o` is 1 together with `rx_valid_o` when the parity bit disagrees with R3 or when the stop bit is sampled low. A single flag covers both causes, and `rx_err_o` is never 1 without `rx_valid_o`.
- R5: When a character completes while `fifo_full_i` is 1, `rx_ovr_o` pulses for one cycle, `rx_valid_o` stays 0 and the character is lost. The next character arriving with room is delivered normally.
- R6: A low level first seen on a tick starts a frame. If the line is high again at the fourth tick after that, the frame is abandoned and nothing is reported.
- R7: Only the first stop bit is examined. A new start bit may directly follow a single stop bit, whatever stop length the transmitter uses.
- R8: With `loop_en_i` at 1, the receiver reads `tx_loop_i` and ignores `rx_pin_i`. With it at 0, the receiver reads `rx_pin_i`.
- R9: `rts_o` (1 = asserted) is 0 one cycle after `autoflow_en_i` and `fifo_afull_i` are both 1. Otherwise it is 1 one cycle later.
- R10: Each accepted character produces exactly one `rx_valid_o` pulse lasting one clock. Data bits are taken at tick 4 of each 8-tick bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Strobe at eight times the bit rate |
| rx_pin_i | input | 1 | Serial input from the pin |
| tx_loop_i | input | 1 | Local transmitter output, used in loopback |
| loop_en_i | input | 1 | 1 selects the loopback source |
| wlen_code_i | input | 2 | Character length code |
| par_code_i | input | 3 | Parity handling code |
| autoflow_en_i | input | 1 | Enables automatic request-to-send |
| fifo_full_i | input | 1 | Receive queue cannot take a character |
| fifo_afull_i | input | 1 | Receive queue is almost full |
| rx_valid_o | output | 1 | One-cycle strobe: character delivered |
| rx_data_o | output | DATA_W | Received character, zero-extended |
| rx_err_o | output | 1 | Parity or stop-bit error for this character |
| rx_ovr_o | output | 1 | One-cycle strobe: character lost to a full queue |
| rts_o | output | 1 | Request to send, 1 = asserted |

## Verification
A tick counter or bit index that drifts shows up within the same character. The data comes out rotated or truncated, or the parity and stop checks land on the wrong bit and raise a false `rx_err_o` at the end of that frame. A state machine that fails to return to idle shows up one frame later, as a missing `rx_valid_o` for the next character sent. Every test therefore counts strobes per frame rather than only inspecting the last value. A start-bit check taken at the wrong tick is exposed within two frame times by the short-glitch test, through a spurious delivery.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   localparam logic [2:0] PAR_ODD   = 3'd4;
   localparam logic [2:0] PAR_MARK  = 3'd5;
   localparam logic [2:0] PAR_EVEN  = 3'd6;
   localparam logic [2:0] PAR_SPACE = 3'd7;

   // number of data bits for a length code
   function automatic logic [3:0] word_bits(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

   // parity bit present on the line
   function automatic logic par_used(input logic [2:0] code);
      return code[2];
   endfunction

   // expected parity bit given the xor of the received data bits
   function automatic logic par_expected(input logic [2:0] code, input logic ones_odd);
      logic r;
      case (code)
         PAR_ODD:   r = ~ones_odd;
         PAR_EVEN:  r = ones_odd;
         PAR_MARK:  r = 1'b1;
         PAR_SPACE: r = 1'b0;
         default:   r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/uart_rx_line_in.sv
module uart_rx_line_in #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_pin_i,
   input  logic tx_loop_i,
   input  logic loop_en_i,
   output logic line_o
);

   logic raw;
   assign raw = loop_en_i ? tx_loop_i : rx_pin_i;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign line_o = raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign line_o = sh_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int unsigned OSR    = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              line_i,
   input  logic [1:0]        wlen_i,
   input  logic [2:0]        par_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              err_o
);

   localparam int unsigned CNT_W = $clog2(OSR);
   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   rx_state_e         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              acc_q;
   logic              pbit_q;
   logic              prev_q;
   logic              last_bit;

   assign last_bit = (int'(idx_q) + 1) == int'(word_bits(wlen_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
         acc_q  <= 1'b0;
         pbit_q <= 1'b0;
         prev_q <= 1'b1;
      end else if (tick_i) begin
         prev_q <= line_i;
         unique case (st_q)
            ST_IDLE: begin
               if (prev_q && !line_i) begin
                  st_q  <= ST_START;
                  cnt_q <= CNT_W'(1);
                  idx_q <= '0;
                  sh_q  <= '0;
                  acc_q <= 1'b0;
               end
            end
            ST_START: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == MID && line_i) begin
                  st_q <= ST_IDLE;
               end else if (cnt_q == LAST) begin
                  st_q  <= ST_DATA;
                  cnt_q <= '0;
               end
            end
            ST_DATA: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == MID) begin
                  sh_q[idx_q] <= line_i;
                  acc_q       <= acc_q ^ line_i;
               end
               if (cnt_q == LAST) begin
                  cnt_q <= '0;
                  if (last_bit) begin
                     st_q <= par_used(par_i) ? ST_PAR : ST_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == MID) begin
                  pbit_q <= line_i;
               end
               if (cnt_q == LAST) begin
                  cnt_q <= '0;
                  st_q  <= ST_STOP;
               end
            end
            ST_STOP: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == MID) begin
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o = tick_i && (st_q == ST_STOP) && (cnt_q == MID);
   assign data_o = sh_q;
   assign err_o  = !line_i ||
                   (par_used(par_i) && (pbit_q != par_expected(par_i, acc_q)));

endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic autoflow_en_i,
   input  logic fifo_afull_i,
   output logic rts_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rts_o <= 1'b0;
      end else begin
         rts_o <= !(autoflow_en_i && fifo_afull_i);
      end
   end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int unsigned OSR         = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              os_tick_i,
   input  logic              rx_pin_i,
   input  logic              tx_loop_i,
   input  logic              loop_en_i,
   input  logic [1:0]        wlen_code_i,
   input  logic [2:0]        par_code_i,
   input  logic              autoflow_en_i,
   input  logic              fifo_full_i,
   input  logic              fifo_afull_i,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_err_o,
   output logic              rx_ovr_o,
   output logic              rts_o
);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_rx_core: OSR must be even and at least 4");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("uart_rx_core: DATA_W must be at least 8");
      end
   endgenerate

   logic              line;
   logic              done;
   logic              err_n;
   logic [DATA_W-1:0] data_n;

   uart_rx_line_in #(
      .SYNC_STAGES (SYNC_STAGES)
   ) line_i0 (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rx_pin_i  (rx_pin_i),
      .tx_loop_i (tx_loop_i),
      .loop_en_i (loop_en_i),
      .line_o    (line)
   );

   uart_rx_frame #(
      .OSR    (OSR),
      .DATA_W (DATA_W)
   ) frame_i0 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (os_tick_i),
      .line_i (line),
      .wlen_i (wlen_code_i),
      .par_i  (par_code_i),
      .done_o (done),
      .data_o (data_n),
      .err_o  (err_n)
   );

   uart_rx_rts rts_i0 (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .autoflow_en_i (autoflow_en_i),
      .fifo_afull_i  (fifo_afull_i),
      .rts_o         (rts_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_valid_o <= 1'b0;
         rx_ovr_o   <= 1'b0;
         rx_err_o   <= 1'b0;
         rx_data_o  <= '0;
      end else begin
         rx_valid_o <= done && !fifo_full_i;
         rx_ovr_o   <= done && fifo_full_i;
         rx_err_o   <= done && !fifo_full_i && err_n;
         if (done && !fifo_full_i) begin
            rx_data_o <= data_n;
         end
      end
   end

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              fifo_full_i,
   input logic              fifo_afull_i,
   input logic              autoflow_en_i,
   input logic [1:0]        wlen_code_i,
   input logic              rx_valid_o,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rx_err_o,
   input logic              rx_ovr_o,
   input logic              rts_o
);

   // R10
   valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o |=> !rx_valid_o);

   // R5
   valid_ovr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rx_valid_o && rx_ovr_o));

   // R5
   ovr_after_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_ovr_o |-> $past(fifo_full_i));

   // R4
   err_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_err_o |-> rx_valid_o);

   // R9
   rts_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (autoflow_en_i && fifo_afull_i) |=> !rts_o);

   // R2
   short_zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_o && wlen_code_i == 2'd0) |-> (rx_data_o[DATA_W-1:5] == '0));

endmodule

bind uart_rx_core uart_rx_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 2;
   localparam int OSR        = 8;
   localparam int BIT_CLKS   = OSR * TICK_DIV;
   localparam int NVEC       = 13;

   // {wlen[2], par[3], data[8], flip_par, stop_level, exp_data[8], exp_err}
   localparam logic [23:0] VEC [NVEC] = '{
      {2'd3, 3'd0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0},
      {2'd0, 3'd0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0},
      {2'd1, 3'd0, 8'hC3, 1'b0, 1'b1, 8'h03, 1'b0},
      {2'd2, 3'd0, 8'hD5, 1'b0, 1'b1, 8'h55, 1'b0},
      {2'd3, 3'd4, 8'h37, 1'b0, 1'b1, 8'h37, 1'b0},
      {2'd3, 3'd6, 8'h37, 1'b0, 1'b1, 8'h37, 1'b0},
      {2'd3, 3'd5, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0},
      {2'd3, 3'd7, 8'hFF, 1'b0, 1'b1, 8'hFF, 1'b0},
      {2'd3, 3'd6, 8'h37, 1'b1, 1'b1, 8'h37, 1'b1},
      {2'd3, 3'd0, 8'h5A, 1'b0, 1'b0, 8'h5A, 1'b1},
      {2'd0, 3'd4, 8'h15, 1'b1, 1'b1, 8'h15, 1'b1},
      {2'd3, 3'd2, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0},
      {2'd3, 3'd5, 8'h81, 1'b1, 1'b1, 8'h81, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rx_pin = 1'b1;
   logic       tx_loop = 1'b1;
   logic       loop_en = 1'b0;
   logic [1:0] wlen = 2'd3;
   logic [2:0] par = 3'd0;
   logic       autoflow = 1'b0;
   logic       full = 1'b0;
   logic       afull = 1'b0;
   logic       valid;
   logic [7:0] data;
   logic       err;
   logic       ovr;
   logic       rts;

   int checks = 0;
   int errors = 0;
   int n_valid = 0;
   int n_err = 0;
   int n_ovr = 0;
   int div_cnt = 0;
   logic [7:0] last_data = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (div_cnt == TICK_DIV - 1) begin
         div_cnt = 0;
         tick = 1'b1;
      end else begin
         div_cnt = div_cnt + 1;
         tick = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (valid) begin
            n_valid = n_valid + 1;
            last_data = data;
            if (err) n_err = n_err + 1;
         end
         if (ovr) n_ovr = n_ovr + 1;
      end
   end

   uart_rx_core dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .os_tick_i     (tick),
      .rx_pin_i      (rx_pin),
      .tx_loop_i     (tx_loop),
      .loop_en_i     (loop_en),
      .wlen_code_i   (wlen),
      .par_code_i    (par),
      .autoflow_en_i (autoflow),
      .fifo_full_i   (full),
      .fifo_afull_i  (afull),
      .rx_valid_o    (valid),
      .rx_data_o     (data),
      .rx_err_o      (err),
      .rx_ovr_o      (ovr),
      .rts_o         (rts)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_line(input bit via_loop, input logic v);
      if (via_loop) tx_loop = v;
      else rx_pin = v;
   endtask

   task automatic hold_bit(input bit via_loop, input logic v);
      drive_line(via_loop, v);
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send_frame(input bit via_loop, input logic [1:0] w, input logic [2:0] p,
                             input logic [7:0] d, input bit flip, input logic stop_v,
                             input int idle_bits);
      int   nb;
      logic ones;
      logic pb;
      nb = 5 + int'(w);
      ones = 1'b0;
      hold_bit(via_loop, 1'b0);
      for (int i = 0; i < nb; i++) begin
         hold_bit(via_loop, d[i]);
         ones ^= d[i];
      end
      if (p[2]) begin
         case (p)
            3'd4:    pb = ~ones;
            3'd5:    pb = 1'b1;
            3'd6:    pb = ones;
            default: pb = 1'b0;
         endcase
         hold_bit(via_loop, pb ^ flip);
      end
      hold_bit(via_loop, stop_v);
      drive_line(via_loop, 1'b1);
      repeat (idle_bits * BIT_CLKS) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int bv;
      int be;
      int bo;
      repeat (5) @(negedge clk);
      // R1 reset state
      check("R1", "valid in reset", valid, 0);
      check("R1", "ovr in reset", ovr, 0);
      check("R1", "err in reset", err, 0);
      check("R1", "rts in reset", rts, 0);
      rst_n = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);

      // table walk: R2 lengths, R3 parity codes, R4 error merge, R10 one pulse
      for (int k = 0; k < NVEC; k++) begin
         logic [23:0] v;
         v = VEC[k];
         bv = n_valid;
         be = n_err;
         wlen = v[23:22];
         par = v[21:19];
         @(negedge clk);
         send_frame(1'b0, v[23:22], v[21:19], v[18:11], v[10], v[9], 2);
         check("R10", $sformatf("vector %0d pulses", k), n_valid - bv, 1);
         check("R2/R3", $sformatf("vector %0d data", k), last_data, v[8:1]);
         check("R4", $sformatf("vector %0d error", k), n_err - be, v[0]);
      end

      // R6 short low glitch is rejected
      wlen = 2'd3;
      par = 3'd0;
      bv = n_valid;
      bo = n_ovr;
      rx_pin = 1'b0;
      repeat (2 * TICK_DIV) @(negedge clk);
      rx_pin = 1'b1;
      repeat (12 * BIT_CLKS) @(negedge clk);
      check("R6", "glitch pulses", n_valid - bv, 0);
      check("R6", "glitch overruns", n_ovr - bo, 0);
      bv = n_valid;
      send_frame(1'b0, 2'd3, 3'd0, 8'h6C, 1'b0, 1'b1, 2);
      check("R6", "frame after glitch count", n_valid - bv, 1);
      check("R6", "frame after glitch data", last_data, 8'h6C);

      // R5 overrun while queue full
      full = 1'b1;
      bv = n_valid;
      bo = n_ovr;
      send_frame(1'b0, 2'd3, 3'd0, 8'h3C, 1'b0, 1'b1, 2);
      full = 1'b0;
      check("R5", "overrun strobes", n_ovr - bo, 1);
      check("R5", "no delivery when full", n_valid - bv, 0);
      check("R5", "data kept", last_data, 8'h6C);
      bv = n_valid;
      send_frame(1'b0, 2'd3, 3'd0, 8'hC9, 1'b0, 1'b1, 2);
      check("R5", "delivery after full clears", n_valid - bv, 1);
      check("R5", "data after full clears", last_data, 8'hC9);

      // R7 back-to-back frames, single stop bit, even parity
      wlen = 2'd2;
      par = 3'd6;
      @(negedge clk);
      bv = n_valid;
      be = n_err;
      send_frame(1'b0, 2'd2, 3'd6, 8'h41, 1'b0, 1'b1, 0);
      send_frame(1'b0, 2'd2, 3'd6, 8'h7E, 1'b0, 1'b1, 2);
      check("R7", "back-to-back count", n_valid - bv, 2);
      check("R7", "back-to-back last data", last_data, 8'h7E);
      check("R7", "back-to-back errors", n_err - be, 0);

      // R8 loopback source
      wlen = 2'd3;
      par = 3'd0;
      loop_en = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);
      rx_pin = 1'b0;
      bv = n_valid;
      be = n_err;
      send_frame(1'b1, 2'd3, 3'd0, 8'h96, 1'b0, 1'b1, 2);
      check("R8", "loopback count", n_valid - bv, 1);
      check("R8", "loopback data", last_data, 8'h96);
      check("R8", "loopback error", n_err - be, 0);
      rx_pin = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);
      bv = n_valid;
      send_frame(1'b0, 2'd3, 3'd0, 8'h00, 1'b0, 1'b0, 2);
      check("R8", "pin ignored in loopback", n_valid - bv, 0);
      loop_en = 1'b0;
      repeat (2 * BIT_CLKS) @(negedge clk);
      bv = n_valid;
      send_frame(1'b0, 2'd3, 3'd0, 8'h5E, 1'b0, 1'b1, 2);
      check("R8", "pin used again", last_data, 8'h5E);

      // R9 request to send
      autoflow = 1'b1;
      afull = 1'b1;
      repeat (2) @(negedge clk);
      check("R9", "rts with afull", rts, 0);
      afull = 1'b0;
      repeat (2) @(negedge clk);
      check("R9", "rts with room", rts, 1);
      autoflow = 1'b0;
      afull = 1'b1;
      repeat (2) @(negedge clk);
      check("R9", "rts without autoflow", rts, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule